// File: doc/BRIEF.md
# Snooped Bus Message Group Filter

This block watches every tagged message on a shared snooping bus and decides, one cycle later, whether the local node should take it. Each protected message carries a group tag and the tag of the processor that sent it. The filter holds a membership bit matrix with one row per group and one column per processor. It also holds a per-group table with an occupied flag, a session key, a mask word and an authentication interval. A message is taken only when the matrix bit at (group, originator) is set. On a take, the group's table index and its stored key, mask and interval are presented for the decrypt stage that follows. All other protected messages are flagged as discarded. A node never legitimately hears its own traffic, so a message in a served group that carries the local processor number raises a spoofing alarm.

Software-free configuration commands arrive on a valid/ready stream. They set or clear membership bits, load a table entry, or free a group. A command that targets the group being looked up in the same cycle is accepted but held for exactly one cycle. While it is held, `cfg_ready` is low, so an upstream source keeps its next command until ready returns. The snoop input has no ready signal, because a bus that is being snooped cannot be stalled. Allocation requests are plain strobes. Up to two can be served per cycle, and each gets a registered result.

The group tag indexes the table directly, so the table index returned with a take equals the group tag. Defaults are 16 groups and 8 processors. Both are parameters, and the tag widths are derived from them.

Top module: `grp_filter`

## Requirements
- R1: After reset, every membership bit and occupied flag is clear, all output strobes are low and `cfg_ready` is high.
- R2: A snoop with `snp_valid` high and `snp_type` not 0 gives `acc_valid` high in the next cycle, with `acc_idx` equal to its group tag, when the matrix bit (group, originator) is set and the originator differs from `my_pid`.
- R3: Any other snoop with `snp_type` not 0 gives `disc` high in the next cycle and `acc_valid` low. This includes every snoop in a group whose row is all zero.
- R4: A snoop with `snp_type` not 0, originator equal to `my_pid` and the bit (group, `my_pid`) set gives `spoof_alarm` and `disc` in the next cycle, and no accept.
- R5: A snoop with `snp_type` 0 is unprotected traffic. It gives none of `acc_valid`, `disc` or `spoof_alarm`.
- R6: Command op 0 sets the bit (`cfg_gid`, `cfg_pid`) and op 1 clears it. A command takes effect for lookups from the cycle after it is applied.
- R7: Command op 2 stores `cfg_key`, `cfg_mask` and `cfg_ival` for group `cfg_gid`. An accept returns these values on `acc_key`, `acc_mask` and `acc_ival`.
- R8: Allocation request bit 0 is granted the lowest unoccupied index. Bit 1 is granted the next unoccupied index above it, or the lowest unoccupied index when bit 0 is not requesting. The result appears in the next cycle on `alloc_ok` and `alloc_idx` (bits [GID_W-1:0] for request 0, the bits above them for request 1), and the granted entries become occupied.
- R9: A request that finds no unoccupied entry gives `alloc_wait` for that request in the next cycle, with `alloc_ok` low and no change to occupancy.
- R10: Command op 3 clears the group's occupied flag and its whole membership row in the same cycle. Its messages are then discarded, and the index can be allocated again.
- R11: A command accepted while a protected snoop carries the same group tag is applied one cycle later, not in that cycle. During the hold, `cfg_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| my_pid | input | PID_W | Processor number of the local node |
| snp_valid | input | 1 | Snooped message present |
| snp_type | input | 2 | Message kind, 0 = unprotected |
| snp_gid | input | GID_W | Group tag of the message |
| snp_pid | input | PID_W | Originating processor of the message |
| cfg_valid | input | 1 | Configuration command valid |
| cfg_ready | output | 1 | Configuration command can be taken |
| cfg_op | input | 2 | 0 set bit, 1 clear bit, 2 load entry, 3 free group |
| cfg_gid | input | GID_W | Target group |
| cfg_pid | input | PID_W | Target processor for ops 0 and 1 |
| cfg_key | input | KEY_W | Session key for op 2 |
| cfg_mask | input | KEY_W | Mask word for op 2 |
| cfg_ival | input | IVL_W | Authentication interval for op 2 |
| alloc_req | input | 2 | Allocation request strobes |
| alloc_ok | output | 2 | Per-request grant, one cycle after the request |
| alloc_wait | output | 2 | Per-request no-free-entry, retry later |
| alloc_idx | output | 2*GID_W | Granted indices, request 0 in the low field |
| acc_valid | output | 1 | Message accepted |
| acc_idx | output | GID_W | Table index of the accepted group |
| acc_key | output | KEY_W | Key of the accepted group |
| acc_mask | output | KEY_W | Mask of the accepted group |
| acc_ival | output | IVL_W | Authentication interval of the accepted group |
| disc | output | 1 | Protected message discarded |
| spoof_alarm | output | 1 | Message claims to come from the local node |

## Verification
A wrong membership bit shows up at the first later snoop of that (group, originator) pair, exactly one cycle after the snoop: an accept and a discard trade places, or an alarm appears or goes missing. A stale occupied flag shows up in the first allocation after it, as a wrong `alloc_idx` or a wrong `alloc_wait`. A mistimed configuration hold shows up as a result that is one cycle early or late, which the directed same-group collision and the random traffic both expose, and as `cfg_ready` being high or low in the wrong cycle. A corrupted table word is visible on the next accept of that group.

// File: rtl/grpflt_pkg.sv
package grpflt_pkg;
  typedef enum logic [1:0] {
    CFG_SET   = 2'd0,
    CFG_CLR   = 2'd1,
    CFG_ENTRY = 2'd2,
    CFG_FREE  = 2'd3
  } cfg_op_e;
endpackage

// File: rtl/grpflt_cfg_gate.sv
module grpflt_cfg_gate #(
  parameter int GID_W = 4,
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [GID_W-1:0] in_gid,
  input  logic [CMD_W-1:0] in_cmd,
  input  logic             lk_valid,
  input  logic [GID_W-1:0] lk_gid,
  output logic             ap_valid,
  output logic [CMD_W-1:0] ap_cmd
);
  logic             held_q;
  logic [CMD_W-1:0] held_cmd_q;
  logic             clash;

  assign clash    = lk_valid && (lk_gid == in_gid);
  assign in_ready = !held_q;
  assign ap_valid = held_q || (in_valid && !clash);
  assign ap_cmd   = held_q ? held_cmd_q : in_cmd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q     <= 1'b0;
      held_cmd_q <= '0;
    end else if (held_q) begin
      held_q <= 1'b0;
    end else if (in_valid && clash) begin
      held_q     <= 1'b1;
      held_cmd_q <= in_cmd;
    end
  end

  // R11: a colliding command is released in the very next cycle
  a_r11_hold_released: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && lk_valid && (lk_gid == in_gid)) |=> (ap_valid && !in_ready));
  // R11: a hold never lasts two cycles
  a_r11_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);
endmodule

// File: rtl/grpflt_member.sv
module grpflt_member
  import grpflt_pkg::*;
#(
  parameter int NGRP  = 16,
  parameter int NPROC = 8,
  localparam int GID_W = $clog2(NGRP),
  localparam int PID_W = $clog2(NPROC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_op,
  input  logic [GID_W-1:0] wr_gid,
  input  logic [PID_W-1:0] wr_pid,
  input  logic [GID_W-1:0] rd_gid,
  input  logic [PID_W-1:0] rd_pid,
  input  logic [PID_W-1:0] self_pid,
  output logic             hit_orig,
  output logic             hit_self
);
  logic [NPROC-1:0] rows [NGRP];

  assign hit_orig = rows[rd_gid][rd_pid];
  assign hit_self = rows[rd_gid][self_pid];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NGRP; g++) rows[g] <= '0;
    end else if (wr_en) begin
      case (wr_op)
        CFG_SET:  rows[wr_gid][wr_pid] <= 1'b1;
        CFG_CLR:  rows[wr_gid][wr_pid] <= 1'b0;
        CFG_FREE: rows[wr_gid]         <= '0;
        default: ;
      endcase
    end
  end

  // R10: a freed group has an all-zero row afterwards
  a_r10_row_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == CFG_FREE) |=> (rows[$past(wr_gid)] == '0));
  // R6: a set command leaves its bit set
  a_r6_bit_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_op == CFG_SET) |=> rows[$past(wr_gid)][$past(wr_pid)]);
endmodule

// File: rtl/grpflt_table.sv
module grpflt_table
  import grpflt_pkg::*;
#(
  parameter int NGRP  = 16,
  parameter int KEY_W = 128,
  parameter int IVL_W = 8,
  localparam int GID_W = $clog2(NGRP)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_op,
  input  logic [GID_W-1:0]   wr_gid,
  input  logic [KEY_W-1:0]   wr_key,
  input  logic [KEY_W-1:0]   wr_mask,
  input  logic [IVL_W-1:0]   wr_ival,
  input  logic [GID_W-1:0]   rd_gid,
  output logic [KEY_W-1:0]   rd_key,
  output logic [KEY_W-1:0]   rd_mask,
  output logic [IVL_W-1:0]   rd_ival,
  input  logic [1:0]         alloc_req,
  output logic [1:0]         alloc_ok,
  output logic [1:0]         alloc_wait,
  output logic [2*GID_W-1:0] alloc_idx
);
  logic [NGRP-1:0]  occ_q;
  logic [KEY_W-1:0] key_q  [NGRP];
  logic [KEY_W-1:0] mask_q [NGRP];
  logic [IVL_W-1:0] ival_q [NGRP];

  logic             f0_ok, f1_ok;
  logic [GID_W-1:0] f0, f1;
  logic [1:0]       gnt;
  logic [GID_W-1:0] gidx [2];

  assign rd_key  = key_q[rd_gid];
  assign rd_mask = mask_q[rd_gid];
  assign rd_ival = ival_q[rd_gid];

  // two lowest free entries
  always_comb begin
    f0_ok = 1'b0; f0 = '0;
    f1_ok = 1'b0; f1 = '0;
    for (int i = 0; i < NGRP; i++) begin
      if (!occ_q[i]) begin
        if (!f0_ok) begin
          f0_ok = 1'b1; f0 = GID_W'(i);
        end else if (!f1_ok) begin
          f1_ok = 1'b1; f1 = GID_W'(i);
        end
      end
    end
  end

  always_comb begin
    gnt[0]  = alloc_req[0] && f0_ok;
    gidx[0] = f0;
    if (alloc_req[0]) begin
      gnt[1]  = alloc_req[1] && f1_ok;
      gidx[1] = f1;
    end else begin
      gnt[1]  = alloc_req[1] && f0_ok;
      gidx[1] = f0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      occ_q      <= '0;
      alloc_ok   <= '0;
      alloc_wait <= '0;
      alloc_idx  <= '0;
      for (int g = 0; g < NGRP; g++) begin
        key_q[g]  <= '0;
        mask_q[g] <= '0;
        ival_q[g] <= '0;
      end
    end else begin
      if (wr_en && wr_op == CFG_FREE) occ_q[wr_gid] <= 1'b0;
      if (wr_en && wr_op == CFG_ENTRY) begin
        key_q[wr_gid]  <= wr_key;
        mask_q[wr_gid] <= wr_mask;
        ival_q[wr_gid] <= wr_ival;
      end
      for (int r = 0; r < 2; r++) begin
        if (gnt[r]) occ_q[gidx[r]] <= 1'b1;
        alloc_ok[r]   <= gnt[r];
        alloc_wait[r] <= alloc_req[r] && !gnt[r];
        alloc_idx[r*GID_W +: GID_W] <= gnt[r] ? gidx[r] : '0;
      end
    end
  end

  // R8: two simultaneous grants never share an index
  a_r8_distinct_grants: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ok == 2'b11) |-> (alloc_idx[GID_W-1:0] != alloc_idx[2*GID_W-1:GID_W]));
  // R9: a request is either granted or told to wait, never both
  a_r9_ok_wait_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_ok & alloc_wait) == 2'b00);
  // R8: a granted index was free before and is occupied after
  a_r8_grant_occupies: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok[0] |-> occ_q[alloc_idx[GID_W-1:0]]);
endmodule

// File: rtl/grp_filter.sv
module grp_filter #(
  parameter int NGRP  = 16,
  parameter int NPROC = 8,
  parameter int KEY_W = 128,
  parameter int IVL_W = 8,
  localparam int GID_W = $clog2(NGRP),
  localparam int PID_W = $clog2(NPROC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PID_W-1:0]   my_pid,
  input  logic               snp_valid,
  input  logic [1:0]         snp_type,
  input  logic [GID_W-1:0]   snp_gid,
  input  logic [PID_W-1:0]   snp_pid,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic [1:0]         cfg_op,
  input  logic [GID_W-1:0]   cfg_gid,
  input  logic [PID_W-1:0]   cfg_pid,
  input  logic [KEY_W-1:0]   cfg_key,
  input  logic [KEY_W-1:0]   cfg_mask,
  input  logic [IVL_W-1:0]   cfg_ival,
  input  logic [1:0]         alloc_req,
  output logic [1:0]         alloc_ok,
  output logic [1:0]         alloc_wait,
  output logic [2*GID_W-1:0] alloc_idx,
  output logic               acc_valid,
  output logic [GID_W-1:0]   acc_idx,
  output logic [KEY_W-1:0]   acc_key,
  output logic [KEY_W-1:0]   acc_mask,
  output logic [IVL_W-1:0]   acc_ival,
  output logic               disc,
  output logic               spoof_alarm
);
  localparam int CMD_W = 2 + GID_W + PID_W + 2*KEY_W + IVL_W;

  logic             lk;
  logic             ap_valid;
  logic [CMD_W-1:0] ap_cmd;
  logic [1:0]       ap_op;
  logic [GID_W-1:0] ap_gid;
  logic [PID_W-1:0] ap_pid;
  logic [KEY_W-1:0] ap_key, ap_mask;
  logic [IVL_W-1:0] ap_ival;
  logic             hit_orig, hit_self;
  logic [KEY_W-1:0] t_key, t_mask;
  logic [IVL_W-1:0] t_ival;
  logic             take;

  assign lk = snp_valid && (snp_type != 2'd0);
  assign {ap_op, ap_gid, ap_pid, ap_key, ap_mask, ap_ival} = ap_cmd;

  grpflt_cfg_gate #(.GID_W(GID_W), .CMD_W(CMD_W)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .in_valid(cfg_valid), .in_ready(cfg_ready), .in_gid(cfg_gid),
    .in_cmd({cfg_op, cfg_gid, cfg_pid, cfg_key, cfg_mask, cfg_ival}),
    .lk_valid(lk), .lk_gid(snp_gid),
    .ap_valid(ap_valid), .ap_cmd(ap_cmd)
  );

  grpflt_member #(.NGRP(NGRP), .NPROC(NPROC)) u_member (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ap_valid), .wr_op(ap_op), .wr_gid(ap_gid), .wr_pid(ap_pid),
    .rd_gid(snp_gid), .rd_pid(snp_pid), .self_pid(my_pid),
    .hit_orig(hit_orig), .hit_self(hit_self)
  );

  grpflt_table #(.NGRP(NGRP), .KEY_W(KEY_W), .IVL_W(IVL_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ap_valid), .wr_op(ap_op), .wr_gid(ap_gid),
    .wr_key(ap_key), .wr_mask(ap_mask), .wr_ival(ap_ival),
    .rd_gid(snp_gid), .rd_key(t_key), .rd_mask(t_mask), .rd_ival(t_ival),
    .alloc_req(alloc_req), .alloc_ok(alloc_ok),
    .alloc_wait(alloc_wait), .alloc_idx(alloc_idx)
  );

  assign take = lk && hit_orig && (snp_pid != my_pid);

  // one-cycle registered lookup ahead of the decrypt stage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid   <= 1'b0;
      acc_idx     <= '0;
      acc_key     <= '0;
      acc_mask    <= '0;
      acc_ival    <= '0;
      disc        <= 1'b0;
      spoof_alarm <= 1'b0;
    end else begin
      acc_valid   <= take;
      disc        <= lk && !take;
      spoof_alarm <= lk && hit_self && (snp_pid == my_pid);
      if (take) begin
        acc_idx  <= snp_gid;
        acc_key  <= t_key;
        acc_mask <= t_mask;
        acc_ival <= t_ival;
      end
    end
  end

  // R2: an accept always follows a protected snoop of that group
  a_r2_accept_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> ($past(snp_valid) && $past(snp_type) != 2'd0 && acc_idx == $past(snp_gid)));
  // R3: accept and discard never together
  a_r3_accept_xor_discard: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && disc));
  // R4: a spoofing alarm is always a discard
  a_r4_alarm_discards: assert property (@(posedge clk) disable iff (!rst_n)
    spoof_alarm |-> (disc && !acc_valid));
  // R5: unprotected traffic leaves the filter outputs quiet
  a_r5_plain_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_type == 2'd0) |=> $onehot0({acc_valid, disc}) && !acc_valid && !disc);
endmodule

// File: tb/test_grp_filter.sv
module test_grp_filter;
  localparam int  NGRP  = 16;
  localparam int  NPROC = 8;
  localparam int  KEY_W = 128;
  localparam int  IVL_W = 8;
  localparam int  GID_W = $clog2(NGRP);
  localparam int  PID_W = $clog2(NPROC);
  localparam time TCLK  = 10ns;
  localparam logic [PID_W-1:0] MY = 3'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic snp_valid = 0, cfg_valid = 0;
  logic [1:0] snp_type = 0, cfg_op = 0, alloc_req = 0;
  logic [GID_W-1:0] snp_gid = 0, cfg_gid = 0;
  logic [PID_W-1:0] snp_pid = 0, cfg_pid = 0;
  logic [KEY_W-1:0] cfg_key = 0, cfg_mask = 0;
  logic [IVL_W-1:0] cfg_ival = 0;
  logic cfg_ready, acc_valid, disc, spoof_alarm;
  logic [1:0] alloc_ok, alloc_wait;
  logic [2*GID_W-1:0] alloc_idx;
  logic [GID_W-1:0] acc_idx;
  logic [KEY_W-1:0] acc_key, acc_mask;
  logic [IVL_W-1:0] acc_ival;

  always #(TCLK/2) clk = ~clk;

  grp_filter #(.NGRP(NGRP), .NPROC(NPROC), .KEY_W(KEY_W), .IVL_W(IVL_W)) i_grp_filter (
    .clk(clk), .rst_n(rst_n), .my_pid(MY),
    .snp_valid(snp_valid), .snp_type(snp_type), .snp_gid(snp_gid), .snp_pid(snp_pid),
    .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_op(cfg_op), .cfg_gid(cfg_gid),
    .cfg_pid(cfg_pid), .cfg_key(cfg_key), .cfg_mask(cfg_mask), .cfg_ival(cfg_ival),
    .alloc_req(alloc_req), .alloc_ok(alloc_ok), .alloc_wait(alloc_wait), .alloc_idx(alloc_idx),
    .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_key(acc_key), .acc_mask(acc_mask),
    .acc_ival(acc_ival), .disc(disc), .spoof_alarm(spoof_alarm)
  );

  int n_chk = 0, n_fail = 0;

  // reference model
  logic [NPROC-1:0] m_row  [NGRP];
  logic             m_occ  [NGRP];
  logic [KEY_W-1:0] m_key  [NGRP];
  logic [KEY_W-1:0] m_mask [NGRP];
  logic [IVL_W-1:0] m_ival [NGRP];
  logic             m_pend;
  logic [1:0]       p_op;
  logic [GID_W-1:0] p_gid;
  logic [PID_W-1:0] p_pid;
  logic [KEY_W-1:0] p_key, p_mask;
  logic [IVL_W-1:0] p_ival;

  task automatic chk(input bit good, input string req, input logic [KEY_W-1:0] act,
                     input logic [KEY_W-1:0] exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int g = 0; g < NGRP; g++) begin
      m_row[g] = '0; m_occ[g] = 0; m_key[g] = '0; m_mask[g] = '0; m_ival[g] = '0;
    end
    m_pend = 0;
  endtask

  task automatic apply(input logic [1:0] op, input logic [GID_W-1:0] g, input logic [PID_W-1:0] p,
                       input logic [KEY_W-1:0] k, input logic [KEY_W-1:0] m, input logic [IVL_W-1:0] iv);
    case (op)
      2'd0: m_row[g][p] = 1'b1;
      2'd1: m_row[g][p] = 1'b0;
      2'd2: begin m_key[g] = k; m_mask[g] = m; m_ival[g] = iv; end
      default: begin m_row[g] = '0; m_occ[g] = 0; end
    endcase
  endtask

  task automatic step();
    logic e_lk, e_acc, e_disc, e_alarm, e_plain;
    logic [1:0] e_ok, e_wait;
    logic [GID_W-1:0] e_i0, e_i1, gk;
    logic [KEY_W-1:0] e_key, e_mask;
    logic [IVL_W-1:0] e_ival;
    int f0, f1, c;
    chk(cfg_ready === !m_pend, "R11 ready", cfg_ready, !m_pend);
    e_lk    = snp_valid && snp_type != 2'd0;
    e_plain = snp_valid && snp_type == 2'd0;
    e_acc   = e_lk && m_row[snp_gid][snp_pid] && snp_pid != MY;
    e_disc  = e_lk && !e_acc;
    e_alarm = e_lk && m_row[snp_gid][MY] && snp_pid == MY;
    gk = snp_gid; e_key = m_key[gk]; e_mask = m_mask[gk]; e_ival = m_ival[gk];
    f0 = -1; f1 = -1;
    for (int i = 0; i < NGRP; i++)
      if (!m_occ[i]) begin
        if (f0 < 0) f0 = i; else if (f1 < 0) f1 = i;
      end
    e_ok = 0; e_wait = 0; e_i0 = 0; e_i1 = 0;
    if (alloc_req[0]) begin
      if (f0 >= 0) begin e_ok[0] = 1; e_i0 = GID_W'(f0); end else e_wait[0] = 1;
    end
    if (alloc_req[1]) begin
      c = alloc_req[0] ? f1 : f0;
      if (c >= 0) begin e_ok[1] = 1; e_i1 = GID_W'(c); end else e_wait[1] = 1;
    end
    if (m_pend) begin
      apply(p_op, p_gid, p_pid, p_key, p_mask, p_ival);
      m_pend = 0;
    end else if (cfg_valid) begin
      if (e_lk && snp_gid == cfg_gid) begin
        m_pend = 1; p_op = cfg_op; p_gid = cfg_gid; p_pid = cfg_pid;
        p_key = cfg_key; p_mask = cfg_mask; p_ival = cfg_ival;
      end else apply(cfg_op, cfg_gid, cfg_pid, cfg_key, cfg_mask, cfg_ival);
    end
    if (e_ok[0]) m_occ[e_i0] = 1;
    if (e_ok[1]) m_occ[e_i1] = 1;
    @(posedge clk); #1;
    chk(acc_valid === e_acc, "R2 accept", acc_valid, e_acc);
    if (e_acc) begin
      chk(acc_idx === gk, "R2 index", acc_idx, gk);
      chk(acc_key === e_key && acc_mask === e_mask, "R7 key/mask", acc_key, e_key);
      chk(acc_ival === e_ival, "R7 interval", acc_ival, e_ival);
    end
    chk(disc === e_disc, "R3 discard", disc, e_disc);
    chk(spoof_alarm === e_alarm, "R4 alarm", spoof_alarm, e_alarm);
    if (e_plain) chk(!acc_valid && !disc && !spoof_alarm, "R5 plain", {acc_valid, disc}, 0);
    chk(alloc_ok === e_ok, "R8 grant", alloc_ok, e_ok);
    chk(alloc_wait === e_wait, "R9 wait", alloc_wait, e_wait);
    chk(alloc_idx === {e_i1, e_i0}, "R8 index", alloc_idx, {e_i1, e_i0});
  endtask

  task automatic idle();
    snp_valid = 0; cfg_valid = 0; alloc_req = 0;
  endtask

  task automatic snoop(input logic [1:0] t, input logic [GID_W-1:0] g, input logic [PID_W-1:0] p);
    snp_valid = 1; snp_type = t; snp_gid = g; snp_pid = p;
  endtask

  task automatic cmd(input logic [1:0] op, input logic [GID_W-1:0] g, input logic [PID_W-1:0] p);
    cfg_valid = 1; cfg_op = op; cfg_gid = g; cfg_pid = p;
    cfg_key = {$urandom, $urandom, $urandom, $urandom};
    cfg_mask = {$urandom, $urandom, $urandom, $urandom};
    cfg_ival = IVL_W'($urandom);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1 watchdog actual=timeout expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: reset state
    chk(cfg_ready === 1'b1, "R1 ready", cfg_ready, 1);
    chk({acc_valid, disc, spoof_alarm, alloc_ok, alloc_wait} === '0, "R1 outputs",
        {acc_valid, disc, spoof_alarm, alloc_ok, alloc_wait}, 0);
    // R8: two requests on an empty table
    idle(); alloc_req = 2'b11; step();
    chk(alloc_idx === {4'd1, 4'd0}, "R8 pair", alloc_idx, {4'd1, 4'd0});
    // R6: membership of group 0 = {1, MY}
    idle(); cmd(2'd0, 0, 1); step();
    idle(); cmd(2'd0, 0, MY); step();
    idle(); cmd(2'd2, 0, 0); step();
    idle(); snoop(2'd1, 0, 1); step();
    chk(acc_valid === 1'b1, "R6 member accepted", acc_valid, 1);
    idle(); snoop(2'd2, 0, 2); step();
    idle(); snoop(2'd3, 0, MY); step();
    chk(spoof_alarm === 1'b1, "R4 own id", spoof_alarm, 1);
    idle(); snoop(2'd0, 0, 1); step();
    idle(); snoop(2'd1, 5, 1); step();
    // R11: colliding command is held one cycle
    idle(); snoop(2'd1, 0, 2); cmd(2'd0, 0, 2); step();
    idle(); snoop(2'd1, 0, 2); step();
    chk(disc === 1'b1, "R11 held write not yet visible", disc, 1);
    idle(); snoop(2'd1, 0, 2); step();
    chk(acc_valid === 1'b1, "R11 held write now visible", acc_valid, 1);
    // R9: fill the table
    for (int i = 0; i < NGRP - 2; i++) begin idle(); alloc_req = 2'b01; step(); end
    idle(); alloc_req = 2'b10; step();
    chk(alloc_wait === 2'b10, "R9 full", alloc_wait, 2'b10);
    // R10: free group 0
    idle(); cmd(2'd3, 0, 0); step();
    idle(); snoop(2'd1, 0, 1); alloc_req = 2'b01; step();
    chk(disc === 1'b1, "R10 freed row", disc, 1);
    chk(alloc_ok[0] === 1'b1 && alloc_idx[GID_W-1:0] === '0, "R10 index reusable",
        alloc_idx, 0);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      idle();
      if ($urandom_range(0, 3) != 0) snoop(2'($urandom), GID_W'($urandom), PID_W'($urandom));
      if ($urandom_range(0, 2) == 0) begin
        cmd(($urandom_range(0, 9) == 0) ? 2'd3 : 2'($urandom_range(0, 2)),
            GID_W'($urandom), PID_W'($urandom));
        if ($urandom_range(0, 1) == 0) cfg_gid = snp_gid;
      end
      if ($urandom_range(0, 7) == 0) alloc_req = 2'($urandom);
      step();
    end
    idle(); step();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule